// File: doc/BRIEF.md
# Dark-Row Black Level Corrector

This block removes the dark offset from a stream of raw Bayer or monochrome pixels. It measures a separate offset for each of the four colour sites of the 2x2 Bayer cell. To do this it averages the pixels that fall inside a rectangular window placed over the sensor's optically shielded rows. The window position is programmable and so is its size in row pairs and column pairs. The averaging runs over a programmable power-of-two number of frames. Every active pixel then has the offset of its own colour site subtracted, and the result is clamped at zero.

The stream enters as a frame-start pulse, a line-valid level and pixel data, and it leaves one cycle later in the same format. Rows inside the dark window are removed from the output: line-valid stays low for them, so downstream stages see an image that has no shielded rows. A small register port sets the window and the integration length. It reads back the four measured offsets and can switch the subtraction to four offsets written by software. Measurement carries on while the manual offsets are in use.

Top module: `blc_darkrow_top`

## Requirements
- R1: The colour site of a pixel is the index {row[0], col[0]}: 0 red, 1 green on a red row, 2 green on a blue row, 3 blue. The row counts from 0 after each frame-start pulse. The column counts from 0 at the start of each line-valid run. Each of the four sites has its own offset.
- R2: A pixel is sampled when its row lies in [RS, RS + 2^(P+1)) and its column lies in [CS, CS + 2^(C+1)). Sampled pixels are summed per site. The measured offset of a site is floor(sum / 2^(P+C+F)), truncated to the pixel width, with P, C and F taken when the offset is loaded.
- R3: Frames are counted from the first frame-start pulse after reset. At a frame-start pulse that closes the 2^F-th frame since the last load, the block loads all four offsets and clears the sums. The measured offsets change at no other time.
- R4: Outside the dark rows, out_pix = max(in_pix - offset[site], 0), delivered one cycle after the input pixel.
- R5: out_fs is in_fs delayed by one cycle. out_lv is in_lv delayed by one cycle and forced low for rows inside [RS, RS + 2^(P+1)).
- R6: out_pix is zero in every cycle in which out_lv is low.
- R7: When the manual bit is set, the subtraction uses the four written manual offsets. Measurement and offset readback continue unchanged.
- R8: Register map, with a write when reg_we is high at a clock edge and a read that is combinational on reg_addr. Address 0 holds RS and address 1 holds CS. Address 2 holds the shape word: P in bits [2:0], C in [5:3], F in [8:6], manual enable in bit 9. Writes to addresses 4 to 7 set the manual offsets of sites 0 to 3. Reads of addresses 4 to 7 return the measured offsets of sites 0 to 3. Address 3 reads zero and ignores writes.
- R9: After reset all registers and offsets are zero and out_fs, out_lv and out_pix are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_fs | input | 1 | Frame-start pulse, one cycle, outside any line |
| in_lv | input | 1 | Line valid, high for each active pixel |
| in_pix | input | PIX_W | Raw pixel value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| out_fs | output | 1 | Frame-start pulse, realigned |
| out_lv | output | 1 | Line valid with dark rows removed |
| out_pix | output | PIX_W | Corrected pixel value |

## Verification
The properties take for granted that in_fs is never high in the same cycle as in_lv. They also assume that every frame-start pulse comes while the line-valid level is low, and that a line ends before the next pulse arrives. Configuration writes are expected between frames, and the integration length is expected to keep the per-site sums inside their width. The stimulus builds every frame as a pulse, then lines separated by two idle cycles, then trailing idle cycles. It writes registers only in the idle gaps, and it keeps the window and frame counts small, so all of these assumptions hold throughout.

// File: rtl/blc_pkg.sv
package blc_pkg;
  localparam int NCH    = 4;
  localparam int LG_W   = 3;
  localparam int LG_MAX = (1 << LG_W) - 1;

  typedef enum logic [1:0] {
    SITE_R  = 2'd0,
    SITE_GR = 2'd1,
    SITE_GB = 2'd2,
    SITE_B  = 2'd3
  } bayer_site_e;

  typedef struct packed {
    logic            manual_en;
    logic [LG_W-1:0] frm_lg;
    logic [LG_W-1:0] col_lg;
    logic [LG_W-1:0] rowp_lg;
  } shape_t;

  localparam logic [2:0] ADR_ROW   = 3'd0;
  localparam logic [2:0] ADR_COL   = 3'd1;
  localparam logic [2:0] ADR_SHAPE = 3'd2;
endpackage

// File: rtl/blc_regs.sv
module blc_regs
  import blc_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  parameter int DW    = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [2:0]                 addr,
  input  logic [DW-1:0]              wdata,
  input  logic [NCH-1:0][PIX_W-1:0]  meas,
  output logic [DW-1:0]              rdata,
  output logic [ROW_W-1:0]           row_start,
  output logic [COL_W-1:0]           col_start,
  output shape_t                     shape,
  output logic [NCH-1:0][PIX_W-1:0]  man_off
);
  localparam int SHAPE_W = $bits(shape_t);

  logic [ROW_W-1:0]          row_q, row_d;
  logic [COL_W-1:0]          col_q, col_d;
  shape_t                    shape_q, shape_d;
  logic [NCH-1:0][PIX_W-1:0] man_q, man_d;

  always_comb begin
    row_d   = row_q;
    col_d   = col_q;
    shape_d = shape_q;
    man_d   = man_q;
    if (we) begin
      case (addr)
        ADR_ROW:   row_d   = wdata[ROW_W-1:0];
        ADR_COL:   col_d   = wdata[COL_W-1:0];
        ADR_SHAPE: shape_d = shape_t'(wdata[SHAPE_W-1:0]);
        default: begin
          if (addr[2]) man_d[addr[1:0]] = wdata[PIX_W-1:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      shape_q <= '0;
      man_q   <= '0;
    end else if (we) begin
      row_q   <= row_d;
      col_q   <= col_d;
      shape_q <= shape_d;
      man_q   <= man_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_ROW:   rdata[ROW_W-1:0]   = row_q;
      ADR_COL:   rdata[COL_W-1:0]   = col_q;
      ADR_SHAPE: rdata[SHAPE_W-1:0] = shape_q;
      default: begin
        if (addr[2]) rdata[PIX_W-1:0] = meas[addr[1:0]];
      end
    endcase
  end

  assign row_start = row_q;
  assign col_start = col_q;
  assign shape     = shape_q;
  assign man_off   = man_q;
endmodule

// File: rtl/blc_pos.sv
module blc_pos
  import blc_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs,
  input  logic             lv,
  input  logic [ROW_W-1:0] row_start,
  input  logic [COL_W-1:0] col_start,
  input  shape_t           shape,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             dark_row,
  output logic             dark_col,
  output logic             started
);
  localparam int SPAN_W = 32;

  logic [ROW_W-1:0]  row_q, row_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic              lv_q, started_q, started_d;
  logic [ROW_W-1:0]  rel_row;
  logic [COL_W-1:0]  rel_col;
  logic [SPAN_W-1:0] row_span, col_span;

  always_comb begin
    row_d     = row_q;
    col_d     = col_q;
    started_d = started_q;
    if (fs) begin
      row_d     = '0;
      col_d     = '0;
      started_d = 1'b1;
    end else begin
      col_d = lv ? col_q + 1'b1 : '0;
      if (lv_q && !lv) row_d = row_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q     <= '0;
      col_q     <= '0;
      lv_q      <= 1'b0;
      started_q <= 1'b0;
    end else begin
      row_q     <= row_d;
      col_q     <= col_d;
      lv_q      <= lv;
      started_q <= started_d;
    end
  end

  always_comb begin
    rel_row  = row_q - row_start;
    rel_col  = col_q - col_start;
    row_span = SPAN_W'(2) << shape.rowp_lg;
    col_span = SPAN_W'(2) << shape.col_lg;
    dark_row = (row_q >= row_start) && (SPAN_W'(rel_row) < row_span);
    dark_col = (col_q >= col_start) && (SPAN_W'(rel_col) < col_span);
  end

  assign row     = row_q;
  assign col     = col_q;
  assign started = started_q;
endmodule

// File: rtl/blc_accum.sv
module blc_accum
  import blc_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fs,
  input  logic                      lv,
  input  logic [PIX_W-1:0]          pix,
  input  bayer_site_e               site,
  input  logic                      started,
  input  logic                      dark_row,
  input  logic                      dark_col,
  input  shape_t                    shape,
  output logic [NCH-1:0][PIX_W-1:0] meas
);
  localparam int SH_MAX = 3 * LG_MAX;
  localparam int SUM_W  = PIX_W + SH_MAX;
  localparam int SH_W   = $clog2(SH_MAX + 1);

  logic [LG_MAX-1:0] fcnt_q, fcnt_d, fcnt_lim;
  logic [SH_W-1:0]   shift;
  logic              load, take;

  always_comb begin
    fcnt_lim = LG_MAX'((8'd1 << shape.frm_lg) - 8'd1);
    shift    = SH_W'(shape.rowp_lg) + SH_W'(shape.col_lg) + SH_W'(shape.frm_lg);
    load     = fs && started && (fcnt_q >= fcnt_lim);
    take     = started && lv && dark_row && dark_col;
    fcnt_d   = fcnt_q;
    if (fs && started) fcnt_d = load ? '0 : fcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcnt_q <= '0;
    else if (fs) fcnt_q <= fcnt_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_site
    logic [SUM_W-1:0] sum_q, sum_d;
    logic [PIX_W-1:0] avg_q, avg_d;
    logic             hit;

    always_comb begin
      hit   = take && (site == bayer_site_e'(g));
      sum_d = sum_q;
      avg_d = avg_q;
      if (load) begin
        sum_d = '0;
        avg_d = PIX_W'(sum_q >> shift);
      end else if (hit) begin
        sum_d = sum_q + SUM_W'(pix);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q <= '0;
        avg_q <= '0;
      end else if (load || hit) begin
        sum_q <= sum_d;
        avg_q <= avg_d;
      end
    end

    assign meas[g] = avg_q;
  end
endmodule

// File: rtl/blc_sub.sv
module blc_sub
  import blc_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fs,
  input  logic                      lv,
  input  logic [PIX_W-1:0]          pix,
  input  bayer_site_e               site,
  input  logic                      dark_row,
  input  logic                      manual_en,
  input  logic [NCH-1:0][PIX_W-1:0] meas,
  input  logic [NCH-1:0][PIX_W-1:0] man_off,
  output logic                      out_fs,
  output logic                      out_lv,
  output logic [PIX_W-1:0]          out_pix
);
  logic [PIX_W-1:0] off, corr, pix_d;
  logic             lv_d;
  logic             fs_q, lv_q;
  logic [PIX_W-1:0] pix_q;

  always_comb begin
    off   = manual_en ? man_off[site] : meas[site];
    corr  = (pix > off) ? pix - off : '0;
    lv_d  = lv && !dark_row;
    pix_d = lv_d ? corr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q  <= 1'b0;
      lv_q  <= 1'b0;
      pix_q <= '0;
    end else begin
      fs_q  <= fs;
      lv_q  <= lv_d;
      pix_q <= pix_d;
    end
  end

  assign out_fs  = fs_q;
  assign out_lv  = lv_q;
  assign out_pix = pix_q;
endmodule

// File: rtl/blc_darkrow_top.sv
module blc_darkrow_top
  import blc_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  parameter int DW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_fs,
  input  logic             in_lv,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             out_fs,
  output logic             out_lv,
  output logic [PIX_W-1:0] out_pix
);
  logic [1:0]                rst_pipe;
  logic                      rst_sq;
  logic [ROW_W-1:0]          row_start, row;
  logic [COL_W-1:0]          col_start, col;
  shape_t                    shape;
  logic [NCH-1:0][PIX_W-1:0] meas, man_off;
  logic                      dark_row, dark_col, started;
  bayer_site_e               site;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sq = rst_pipe[1];

  assign site = bayer_site_e'({row[0], col[0]});

  blc_regs #(.PIX_W(PIX_W), .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sq), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .meas(meas), .rdata(reg_rdata), .row_start(row_start), .col_start(col_start),
    .shape(shape), .man_off(man_off)
  );

  blc_pos #(.ROW_W(ROW_W), .COL_W(COL_W)) u_pos (
    .clk(clk), .rst_n(rst_sq), .fs(in_fs), .lv(in_lv), .row_start(row_start),
    .col_start(col_start), .shape(shape), .row(row), .col(col),
    .dark_row(dark_row), .dark_col(dark_col), .started(started)
  );

  blc_accum #(.PIX_W(PIX_W)) u_accum (
    .clk(clk), .rst_n(rst_sq), .fs(in_fs), .lv(in_lv), .pix(in_pix), .site(site),
    .started(started), .dark_row(dark_row), .dark_col(dark_col), .shape(shape),
    .meas(meas)
  );

  blc_sub #(.PIX_W(PIX_W)) u_sub (
    .clk(clk), .rst_n(rst_sq), .fs(in_fs), .lv(in_lv), .pix(in_pix), .site(site),
    .dark_row(dark_row), .manual_en(shape.manual_en), .meas(meas), .man_off(man_off),
    .out_fs(out_fs), .out_lv(out_lv), .out_pix(out_pix)
  );
endmodule

// File: rtl/blc_darkrow_chk.sv
module blc_darkrow_chk #(
  parameter int PIX_W = 12,
  parameter int NCH   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_fs,
  input logic                   in_lv,
  input logic [PIX_W-1:0]       in_pix,
  input logic                   out_fs,
  input logic                   out_lv,
  input logic [PIX_W-1:0]       out_pix,
  input logic [NCH*PIX_W-1:0]   meas
);
  // R5
  fs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fs |=> out_fs);

  // R5
  fs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_fs |=> !out_fs);

  // R5
  line_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_lv |-> $past(in_lv));

  // R6
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_lv |-> (out_pix == '0));

  // R4
  no_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_lv |-> (out_pix <= $past(in_pix)));

  // R3
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_fs) |-> $stable(meas));
endmodule

bind blc_darkrow_top blc_darkrow_chk #(.PIX_W(PIX_W), .NCH(blc_pkg::NCH)) u_chk (
  .clk(clk), .rst_n(rst_sq), .in_fs(in_fs), .in_lv(in_lv), .in_pix(in_pix),
  .out_fs(out_fs), .out_lv(out_lv), .out_pix(out_pix), .meas(meas)
);

// File: tb/sim_blc_darkrow_top.sv
module sim_blc_darkrow_top;
  localparam int PW = 12;
  localparam int RW = 11;
  localparam int CW = 11;
  localparam int DW = 12;
  localparam int ROWS = 10;
  localparam int COLS = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_fs, in_lv, reg_we;
  logic [PW-1:0] in_pix;
  logic [2:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          out_fs, out_lv;
  logic [PW-1:0] out_pix;

  int n_vec = 0;
  int n_bad = 0;

  int     m_rs, m_cs, m_p, m_c, m_f;
  bit     m_man;
  int     m_manv[4];
  longint m_sum[4];
  int     m_meas[4];
  bit     m_started;
  int     m_fcnt;

  always #5 clk = ~clk;

  blc_darkrow_top #(.PIX_W(PW), .ROW_W(RW), .COL_W(CW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_fs(in_fs), .in_lv(in_lv), .in_pix(in_pix),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_fs(out_fs), .out_lv(out_lv), .out_pix(out_pix)
  );

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pixval(int f, int r, int c);
    int base[4] = '{60, 40, 44, 90};
    int s = (r % 2) * 2 + (c % 2);
    if (r < 4) return base[s] + ((r * 7 + c * 3 + f * 5) % 16);
    return (r * 37 + c * 11 + f * 13) % 200;
  endfunction

  task automatic cyc(bit fs, bit lv, int pix, bit exp_lv, int exp_pix, string tag);
    @(negedge clk);
    in_fs  = fs;
    in_lv  = lv;
    in_pix = PW'(pix);
    @(posedge clk);
    #1;
    check("R5 frame pulse", int'(out_fs), int'(fs));
    check("R5 line valid", int'(out_lv), int'(exp_lv));
    check(tag, int'(out_pix), exp_pix);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = 3'(a);
    reg_wdata = DW'(d);
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    reg_addr = 3'(a);
    #1;
    check(tag, int'(reg_rdata), exp);
  endtask

  task automatic set_cfg(int rs, int cs, int p, int c, int f, bit man);
    wr(0, rs);
    wr(1, cs);
    wr(2, p | (c << 3) | (f << 6) | (int'(man) << 9));
    m_rs = rs; m_cs = cs; m_p = p; m_c = c; m_f = f; m_man = man;
    rd(2, p | (c << 3) | (f << 6) | (int'(man) << 9), "R8 shape readback");
  endtask

  task automatic frame(int f, string tag);
    cyc(1'b1, 1'b0, 0, 1'b0, 0, "R6 idle");
    // R3: load rule evaluated at the frame-start pulse
    if (m_started) begin
      if (m_fcnt >= (1 << m_f) - 1) begin
        for (int k = 0; k < 4; k++) begin
          m_meas[k] = int'((m_sum[k] >> (m_p + m_c + m_f)) & 64'hFFF);
          m_sum[k]  = 0;
        end
        m_fcnt = 0;
      end else begin
        m_fcnt++;
      end
    end
    m_started = 1'b1;
    for (int r = 0; r < ROWS; r++) begin
      cyc(1'b0, 1'b0, 0, 1'b0, 0, "R6 gap");
      cyc(1'b0, 1'b0, 0, 1'b0, 0, "R6 gap");
      for (int c = 0; c < COLS; c++) begin
        int  pv  = pixval(f, r, c);
        int  s   = (r % 2) * 2 + (c % 2);
        bit  drow = (r >= m_rs) && (r < m_rs + (2 << m_p));
        bit  dcol = (c >= m_cs) && (c < m_cs + (2 << m_c));
        int  off = m_man ? m_manv[s] : m_meas[s];
        int  ex  = (pv > off) ? pv - off : 0;
        if (drow && dcol) m_sum[s] += pv;
        cyc(1'b0, 1'b1, pv, !drow, drow ? 0 : ex, drow ? "R5 dark row removed" : tag);
      end
    end
    cyc(1'b0, 1'b0, 0, 1'b0, 0, "R6 tail");
    cyc(1'b0, 1'b0, 0, 1'b0, 0, "R6 tail");
  endtask

  task automatic read_meas(string tag);
    for (int k = 0; k < 4; k++) rd(4 + k, m_meas[k], tag);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_fs = 1'b0; in_lv = 1'b0; in_pix = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int k = 0; k < 4; k++) begin
      m_sum[k] = 0; m_meas[k] = 0; m_manv[k] = 0;
    end
    m_started = 1'b0; m_fcnt = 0;
    m_rs = 0; m_cs = 0; m_p = 0; m_c = 0; m_f = 0; m_man = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9 out_fs", int'(out_fs), 0);
    check("R9 out_lv", int'(out_lv), 0);
    check("R9 out_pix", int'(out_pix), 0);
    for (int a = 0; a < 8; a++) rd(a, 0, "R9 register");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 map, address 3 ignored
    wr(3, 12'hABC);
    rd(3, 0, "R8 hole");
    set_cfg(2, 4, 0, 1, 1, 1'b0);
    rd(0, 2, "R8 row start");
    rd(1, 4, "R8 col start");

    for (int f = 0; f < 5; f++) begin
      frame(f, "R4 corrected");
      read_meas("R1 R2 R3 measured");
    end

    set_cfg(0, 0, 1, 0, 0, 1'b0);
    for (int f = 5; f < 8; f++) begin
      frame(f, "R4 corrected");
      read_meas("R2 R3 measured");
    end

    wr(4, 30);  m_manv[0] = 30;
    wr(5, 0);   m_manv[1] = 0;
    wr(6, 4095); m_manv[2] = 4095;
    wr(7, 55);  m_manv[3] = 55;
    read_meas("R7 readback stays measured");
    set_cfg(0, 0, 1, 0, 0, 1'b1);
    for (int f = 8; f < 10; f++) begin
      frame(f, "R7 manual offset");
      read_meas("R7 measurement continues");
    end

    set_cfg(0, 0, 1, 0, 0, 1'b0);
    frame(10, "R4 corrected");
    read_meas("R3 measured");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule